// File: doc/BRIEF.md
# Delay-Line Sample to Fractional Phase Decoder

This block sits behind the sampling flops of a time-to-digital converter. Each tap of a delay line carries a copy of the output clock that has been delayed by one more tap than its neighbour. All taps are captured together on the reference clock's rising edge. Bit 0 of the captured word holds the least delayed copy. The block locates the output clock's most recent rising edge in that word, which gives the edge delay in taps. It reads the output period from the same word, using two like steps or one step of each kind.

A boxcar filter over the last few period readings smooths the period. A bit-serial divider then forms the ratio of edge delay to averaged period as an unsigned binary fraction. A word in which the edge cannot be found is flagged rather than decoded, and the previous result stays on the output. The delay line itself lies outside the block; whatever drives `taps_i` supplies the captured words.

Top module: `tdc_phase_decoder`

## Requirements
- R1: The edge delay is the lowest index k, with 1 <= k <= NTAP-1, for which tap k-1 reads 1 and tap k reads 0. This is a falling step in index order. Tap k is bit k of `taps_i`.
- R2: The period sample is taken from the word in one of two ways. If a second falling step exists above the first, the sample is the index difference between the two. Otherwise, if a rising step exists (tap k-1 reads 0 and tap k reads 1, lowest such k), the sample is twice the distance between that k and the edge delay. If neither exists, the word carries no period sample.
- R3: The average period is the floor of the mean of the last 2^AVG_LOG2 period samples. The first sample after reset fills every slot of the window. A word without a period sample leaves the average unchanged.
- R4: For an accepted valid word, `phase_o` becomes floor(edge * 2^FRAC_W / avg). Here avg is the average after the word's own period sample has entered the window.
- R5: When the edge delay is greater than or equal to the average period, `phase_o` saturates to all ones.
- R6: A word is invalid if it has no falling step, or if it has no period sample while no period has been measured since reset. For an invalid word, `invalid_o` pulses for exactly the one cycle after the accepting edge. No result follows, and `phase_o` and the average are left unchanged.
- R7: `phase_o` changes only in cycles in which `phase_vld_o` is high.
- R8: `phase_vld_o` is a one-cycle pulse. It becomes visible right after the FRAC_W-th rising edge that follows the edge at which the word was accepted.
- R9: A word is accepted when the divider is idle or is in its final step. In the final-step case, the finishing result and the new word's load share one edge.
- R10: A word presented while the divider is busy and not in its final step is ignored. It produces no pulse and does not change the average.
- R11: During reset, `phase_o` is 0, both pulses are low, and the average holds no period sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_vld_i | input | 1 | A captured word is present on `taps_i` |
| taps_i | input | NTAP | Captured delay-line word; bit k is the copy delayed by k taps |
| phase_o | output | FRAC_W | Normalized edge delay as an unsigned fraction |
| phase_vld_o | output | 1 | One-cycle pulse when `phase_o` is updated |
| invalid_o | output | 1 | One-cycle pulse when an accepted word could not be decoded |

## Verification
Two events can share one cycle: the divider's finishing result and the acceptance of the next word. The bench provokes this by presenting a second word exactly in the divider's final step. It then requires the first result to appear on time and the second result to appear FRAC_W cycles later. It also presents an undecodable word in that same final step, where `phase_vld_o` and `invalid_o` must rise together. A word presented earlier in the busy window must leave no trace in any later result. All expected phases come from periods and edges built arithmetically in the bench.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  // how the period was read from one captured word
  typedef enum logic [1:0] {
    MEAS_NONE = 2'd0,
    MEAS_HALF = 2'd1,
    MEAS_FULL = 2'd2
  } meas_e;
endpackage

// File: rtl/tdc_edge_scan.sv
module tdc_edge_scan
  import tdc_pkg::*;
#(
  parameter int NTAP = 16,
  localparam int IW = $clog2(NTAP)
) (
  input  logic [NTAP-1:0] taps_i,
  output logic            edge_found_o,
  output logic [IW-1:0]   edge_o,
  output meas_e           meas_o,
  output logic [IW-1:0]   span_o
);

  logic          f1_hit, f2_hit, r_hit;
  logic [IW-1:0] f1_pos, f2_pos, r_pos;

  always_comb begin
    f1_hit = 1'b0;
    f2_hit = 1'b0;
    r_hit  = 1'b0;
    f1_pos = '0;
    f2_pos = '0;
    r_pos  = '0;
    for (int k = 1; k < NTAP; k++) begin
      if (taps_i[k-1] && !taps_i[k]) begin
        if (!f1_hit) begin
          f1_hit = 1'b1;
          f1_pos = IW'(k);
        end else if (!f2_hit) begin
          f2_hit = 1'b1;
          f2_pos = IW'(k);
        end
      end
      if (!taps_i[k-1] && taps_i[k] && !r_hit) begin
        r_hit = 1'b1;
        r_pos = IW'(k);
      end
    end
  end

  always_comb begin
    edge_found_o = f1_hit;
    edge_o       = f1_pos;
    meas_o       = MEAS_NONE;
    span_o       = '0;
    if (f1_hit && f2_hit) begin
      meas_o = MEAS_FULL;
      span_o = f2_pos - f1_pos;
    end else if (f1_hit && r_hit) begin
      meas_o = MEAS_HALF;
      span_o = (r_pos > f1_pos) ? (r_pos - f1_pos) : (f1_pos - r_pos);
    end
  end

endmodule

// File: rtl/tdc_period_avg.sv
module tdc_period_avg #(
  parameter int PW       = 5,
  parameter int AVG_LOG2 = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          upd_i,
  input  logic [PW-1:0] per_i,
  output logic          primed_o,
  output logic [PW-1:0] avg_nxt_o
);

  logic primed_q;
  assign primed_o = primed_q;

  if (AVG_LOG2 == 0) begin : g_direct
    logic [PW-1:0] last_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        last_q   <= '0;
        primed_q <= 1'b0;
      end else if (upd_i) begin
        last_q   <= per_i;
        primed_q <= 1'b1;
      end
    end
    assign avg_nxt_o = upd_i ? per_i : last_q;
  end else begin : g_boxcar
    localparam int DEPTH = 1 << AVG_LOG2;
    localparam int SW    = PW + AVG_LOG2;

    logic [PW-1:0]       hist_q [DEPTH];
    logic [AVG_LOG2-1:0] ptr_q;
    logic [SW-1:0]       sum_q, sum_upd;

    assign sum_upd = sum_q + SW'(per_i) - SW'(hist_q[ptr_q]);

    always_comb begin
      if (!upd_i)        avg_nxt_o = PW'(sum_q >> AVG_LOG2);
      else if (!primed_q) avg_nxt_o = per_i;
      else               avg_nxt_o = PW'(sum_upd >> AVG_LOG2);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        primed_q <= 1'b0;
        sum_q    <= '0;
        ptr_q    <= '0;
        for (int i = 0; i < DEPTH; i++) hist_q[i] <= '0;
      end else if (upd_i) begin
        if (!primed_q) begin
          // first sample after reset fills the whole window
          for (int i = 0; i < DEPTH; i++) hist_q[i] <= per_i;
          sum_q    <= SW'(per_i) << AVG_LOG2;
          primed_q <= 1'b1;
        end else begin
          hist_q[ptr_q] <= per_i;
          sum_q         <= sum_upd;
          ptr_q         <= ptr_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/tdc_frac_div.sv
module tdc_frac_div #(
  parameter int IW = 4,
  parameter int PW = 5,
  parameter int QW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [IW-1:0] num_i,
  input  logic [PW-1:0] den_i,
  output logic          busy_o,
  output logic          last_o,
  output logic          done_o,
  output logic [QW-1:0] quo_o
);

  localparam int CW = $clog2(QW + 1);

  logic [PW-1:0] rem_q, den_q, rem_nxt;
  logic [QW-1:0] acc_q, acc_nxt, quo_q;
  logic [CW-1:0] cnt_q;
  logic          sat_q, done_q, take;
  logic [PW:0]   shl, diff;

  assign busy_o = (cnt_q != '0);
  assign last_o = (cnt_q == CW'(1));
  assign done_o = done_q;
  assign quo_o  = quo_q;

  // one restoring step per cycle; remainder stays below the divisor
  always_comb begin
    shl     = {rem_q, 1'b0};
    diff    = shl - {1'b0, den_q};
    take    = (shl >= {1'b0, den_q});
    rem_nxt = take ? diff[PW-1:0] : shl[PW-1:0];
    acc_nxt = {acc_q[QW-2:0], take};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      den_q  <= '0;
      acc_q  <= '0;
      cnt_q  <= '0;
      sat_q  <= 1'b0;
      done_q <= 1'b0;
      quo_q  <= '0;
    end else begin
      done_q <= last_o;
      if (last_o) quo_q <= sat_q ? '1 : acc_nxt;
      if (start_i) begin
        rem_q <= PW'(num_i);
        den_q <= den_i;
        sat_q <= (PW'(num_i) >= den_i);
        acc_q <= '0;
        cnt_q <= CW'(QW);
      end else if (busy_o) begin
        rem_q <= rem_nxt;
        acc_q <= acc_nxt;
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/tdc_phase_decoder.sv
module tdc_phase_decoder
  import tdc_pkg::*;
#(
  parameter int NTAP     = 16,
  parameter int FRAC_W   = 8,
  parameter int AVG_LOG2 = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_vld_i,
  input  logic [NTAP-1:0]   taps_i,
  output logic [FRAC_W-1:0] phase_o,
  output logic              phase_vld_o,
  output logic              invalid_o
);

  localparam int IW = $clog2(NTAP);
  localparam int PW = $clog2(2 * NTAP);

  logic          edge_found;
  logic [IW-1:0] edge_pos, span;
  meas_e         meas;
  logic [PW-1:0] per_meas, avg_nxt;
  logic          primed, have_per, word_ok;
  logic          accept, upd, start;
  logic          div_busy, div_last;
  logic          invalid_q;

  tdc_edge_scan #(.NTAP(NTAP)) u_scan (
    .taps_i      (taps_i),
    .edge_found_o(edge_found),
    .edge_o      (edge_pos),
    .meas_o      (meas),
    .span_o      (span)
  );

  always_comb begin
    case (meas)
      MEAS_FULL: per_meas = PW'(span);
      MEAS_HALF: per_meas = PW'(span) << 1;
      default:   per_meas = '0;
    endcase
  end

  assign have_per = (meas != MEAS_NONE);
  assign word_ok  = edge_found && (have_per || primed);
  assign accept   = sample_vld_i && (!div_busy || div_last);
  assign upd      = accept && word_ok && have_per;
  assign start    = accept && word_ok;

  tdc_period_avg #(.PW(PW), .AVG_LOG2(AVG_LOG2)) u_avg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .upd_i    (upd),
    .per_i    (per_meas),
    .primed_o (primed),
    .avg_nxt_o(avg_nxt)
  );

  tdc_frac_div #(.IW(IW), .PW(PW), .QW(FRAC_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .num_i  (edge_pos),
    .den_i  (avg_nxt),
    .busy_o (div_busy),
    .last_o (div_last),
    .done_o (phase_vld_o),
    .quo_o  (phase_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) invalid_q <= 1'b0;
    else         invalid_q <= accept && !word_ok;
  end
  assign invalid_o = invalid_q;

endmodule

// File: rtl/tdc_phase_decoder_chk.sv
module tdc_phase_decoder_chk #(
  parameter int FRAC_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sample_vld_i,
  input logic              phase_vld_o,
  input logic              invalid_o,
  input logic [FRAC_W-1:0] phase_o,
  input logic              busy
);

  a_r7_phase_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phase_vld_o |-> $stable(phase_o));

  a_r6_invalid_after_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |-> $past(sample_vld_i));

  a_r8_vld_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_vld_o |=> !phase_vld_o);

  a_r8_vld_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_vld_o |-> $past(busy));

  a_r9_busy_from_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(sample_vld_i));

endmodule

bind tdc_phase_decoder tdc_phase_decoder_chk #(.FRAC_W(FRAC_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sample_vld_i(sample_vld_i),
  .phase_vld_o (phase_vld_o),
  .invalid_o   (invalid_o),
  .phase_o     (phase_o),
  .busy        (div_busy)
);

// File: tb/tdc_phase_decoder_bench.sv
module tdc_phase_decoder_bench;
  localparam int NTAP = 16;
  localparam int F    = 8;
  localparam int K    = 2;
  localparam int WIN  = 1 << K;
  localparam int QMAX = (1 << F) - 1;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            vld = 1'b0;
  logic [NTAP-1:0] taps = '0;
  logic [F-1:0]    phase;
  logic            phase_vld, invalid;

  int checks = 0;
  int errors = 0;
  int hist[WIN];
  bit primed = 0;

  always #10 clk = ~clk;

  tdc_phase_decoder #(.NTAP(NTAP), .FRAC_W(F), .AVG_LOG2(K)) u_tdc_phase_decoder (
    .clk_i(clk), .rst_ni(rst_ni), .sample_vld_i(vld), .taps_i(taps),
    .phase_o(phase), .phase_vld_o(phase_vld), .invalid_o(invalid)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // word with output edge e taps back and period p taps (p even)
  function automatic logic [NTAP-1:0] mk(int e, int p);
    logic [NTAP-1:0] w;
    for (int i = 0; i < NTAP; i++) begin
      int m = ((e - i) % p + p) % p;
      w[i] = (m >= 1) && (m <= p / 2);
    end
    return w;
  endfunction

  function automatic void model_upd(int p);
    if (!primed) begin
      for (int i = 0; i < WIN; i++) hist[i] = p;
      primed = 1;
    end else begin
      for (int i = 0; i < WIN - 1; i++) hist[i] = hist[i+1];
      hist[WIN-1] = p;
    end
  endfunction

  function automatic int model_avg();
    int s = 0;
    for (int i = 0; i < WIN; i++) s += hist[i];
    return s / WIN;
  endfunction

  function automatic int exp_phase(int e);
    int a = model_avg();
    return (e >= a) ? QMAX : (e * (1 << F)) / a;
  endfunction

  task automatic pulse(logic [NTAP-1:0] w);
    taps = w;
    vld  = 1'b1;
    @(negedge clk);
    vld  = 1'b0;
  endtask

  task automatic run_one(logic [NTAP-1:0] w, bit exp_inv, int exp_ph, string req);
    int prev = phase;
    pulse(w);
    check(invalid == exp_inv, {req, "/R6 invalid"}, invalid, exp_inv);
    for (int n = 1; n <= F + 1; n++) begin
      @(negedge clk);
      if (n == F && !exp_inv) begin
        check(phase_vld == 1'b1, "R8 latency", phase_vld, 1);
        check(phase == exp_ph, req, phase, exp_ph);
      end else begin
        if (phase_vld) check(1'b0, "R8 stray pulse", phase_vld, 0);
        if (n < F || exp_inv) if (phase != prev) check(1'b0, "R7 hold", phase, prev);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int e1, e2;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(phase == 0, "R11 phase", phase, 0);
    check(phase_vld == 0, "R11 vld", phase_vld, 0);
    check(invalid == 0, "R11 invalid", invalid, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R6: edge but no period before any measurement
    run_one(16'h00FF, 1, 0, "R6 unprimed");
    run_one(16'h0000, 1, 0, "R6 zeros");
    run_one(16'hFFFF, 1, 0, "R6 ones");
    run_one(16'hFF00, 1, 0, "R6 rise only");
    // R11/R3: still unprimed, first sample fills window
    model_upd(8);
    run_one(mk(2, 8), 0, exp_phase(2), "R3/R11 first fill");

    // R1/R2/R4/R5 sweep over periods and edges (full and half period reads)
    for (int p = 4; p <= 14; p += 2) begin
      for (int e = 1; e <= p; e++) begin
        model_upd(p);
        run_one(mk(e, p), 0, exp_phase(e), "R1/R2/R4/R5 sweep");
      end
    end

    // R3: no period in word, average kept (avg 14)
    run_one(16'h00FF, 0, exp_phase(8), "R3/R4 hold avg");
    // R5: edge 15 over avg 14
    run_one(16'h7FFF, 0, QMAX, "R5 saturate");

    // R9: second word in final divide step
    model_upd(6); e1 = exp_phase(3);
    pulse(mk(3, 6));
    repeat (F - 1) @(negedge clk);
    model_upd(10); e2 = exp_phase(7);
    pulse(mk(7, 10));
    check(phase_vld == 1 && phase == e1, "R9 first result", phase, e1);
    repeat (F) @(negedge clk);
    check(phase_vld == 1 && phase == e2, "R9 second result", phase, e2);
    @(negedge clk);

    // R9/R6: undecodable word in final step
    model_upd(8); e1 = exp_phase(5);
    pulse(mk(5, 8));
    repeat (F - 1) @(negedge clk);
    pulse(16'h0000);
    check(phase_vld == 1 && phase == e1, "R9 result with invalid", phase, e1);
    check(invalid == 1, "R6/R9 invalid same cycle", invalid, 1);
    repeat (F + 1) @(negedge clk);
    check(phase_vld == 0, "R6 no result", phase_vld, 0);

    // R10: word mid-busy ignored
    model_upd(12); e1 = exp_phase(4);
    pulse(mk(4, 12));
    repeat (2) @(negedge clk);
    pulse(mk(1, 4));
    repeat (F - 3) @(negedge clk);
    check(phase_vld == 1 && phase == e1, "R10 owner result", phase, e1);
    repeat (3) @(negedge clk);
    check(phase_vld == 0, "R10 no extra pulse", phase_vld, 0);
    @(negedge clk);
    run_one(16'h003F, 0, exp_phase(6), "R10 average untouched");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule